// File: doc/BRIEF.md
# Remote Terminal Status Register

This block keeps the status word that a MIL-STD-1553B remote terminal sends back after each command. The protocol sequencer signals each newly accepted command with a one-cycle pulse. A fixed number of clock cycles later, the block takes a snapshot of the subsystem's active-low request pins: service request, busy, subsystem flag and terminal flag. It also decides whether to grant dynamic bus control. It combines these bits with the message-error condition, the broadcast indication and the terminal's own address to form the 16-bit status word.

The same block owns two sticky fault outputs. The first is a message-error pin that latches on any received word or format error. The second is a terminal-fail pin that latches on a self-test failure or a watchdog expiry. The block also serves the two parallel-bus read windows. In the status window, the status word is on the bus while an active-low enable is asserted. In the built-in-test window, the BIT word is on the bus while a second active-low enable is asserted.

Top module: `rtsr_top`

## Requirements
- R1: While rst is high and in the first cycle after it falls, status_word equals {rt_addr, 11'b0}, and mess_err_n, rt_fail_n, stat_en_n and bit_en_n are all 1.
- R2: The status word is laid out as follows. Bits [15:11] are rt_addr and bit 10 is message error. Bit 9 is always 0. Bit 8 is service request. Bits [7:5] are always 0. Bit 4 is broadcast received. Bit 3 is busy, bit 2 is subsystem flag, bit 1 is dynamic bus control accepted and bit 0 is terminal flag.
- R3: Bits 8, 3, 2 and 0 are loaded with the inverse of srq_n, busy_n, ssflag_n and rtflag_n. The load happens on the clock edge UPDATE_DLY cycles after the edge that takes cmd_valid. At every other edge these bits hold their value.
- R4: Bit 1 is set at the update instant only if all of these are true: accept_dbc_n is low; the command has T/R (bit 10) = 1; the subaddress (bits [9:5]) is 00000 or 11111; the mode code (bits [4:0]) is 00000; the command was not a broadcast; and it was not marked illegal. Otherwise bit 1 is cleared.
- R5: On a rising edge of in_cmd, illegal_n is captured. If it is low, the command is marked illegal and bit 10 is set. A word_err pulse also sets bit 10. A cmd_valid pulse clears bit 10 and the illegal mark, unless word_err is high in that same cycle.
- R6: On cmd_valid, bit 4 is set if cmd_word[15:11] is 11111 and bcast_en is high. Otherwise it is cleared.
- R7: mess_err_n goes low on the cycle after word_err and stays low until the cycle after a cmd_valid without word_err.
- R8: rt_fail_n goes low on the cycle after selftest_fail or wdog_to. stat_tx_start returns it high on the next cycle, unless a fault input is high in that same cycle, in which case it stays low.
- R9: A stat_rd pulse accepted while no read window is open drives stat_en_n low for exactly STAT_LEN cycles, starting on the next cycle. During that window par_data equals status_word.
- R10: A bit_rd pulse accepted while no window is open drives bit_en_n low for exactly BIT_LEN cycles. During that window par_data equals the bit_word captured at the request, zero-extended to 16 bits. A request that arrives while a window is open is ignored. If stat_rd and bit_rd arrive together, only the status window opens. When no window is open, par_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_addr | input | 5 | Terminal address placed in the status word |
| bcast_en | input | 1 | Address 31 is treated as broadcast when high |
| cmd_valid | input | 1 | One-cycle pulse for a newly accepted command |
| cmd_word | input | 16 | Received command word, valid with cmd_valid |
| in_cmd | input | 1 | High while the terminal services a command |
| illegal_n | input | 1 | Active-low illegal-command mark from the subsystem |
| accept_dbc_n | input | 1 | Active-low acceptance of dynamic bus control |
| srq_n | input | 1 | Active-low service request |
| busy_n | input | 1 | Active-low busy |
| ssflag_n | input | 1 | Active-low subsystem flag |
| rtflag_n | input | 1 | Active-low terminal flag |
| word_err | input | 1 | Pulse on a received word or format error |
| selftest_fail | input | 1 | Pulse on a self-test failure |
| wdog_to | input | 1 | Pulse on a transmitter watchdog expiry |
| stat_tx_start | input | 1 | Pulse when a status word transmission begins |
| stat_rd | input | 1 | Request for a status read window |
| bit_rd | input | 1 | Request for a built-in-test read window |
| bit_word | input | BIT_W | Built-in-test word |
| status_word | output | 16 | Current status word |
| mess_err_n | output | 1 | Sticky active-low message error |
| rt_fail_n | output | 1 | Latched active-low terminal fail |
| stat_en_n | output | 1 | Active-low status read window |
| bit_en_n | output | 1 | Active-low built-in-test read window |
| par_data | output | 16 | Parallel bus data during a read window |

## Verification
Several properties are checked on every cycle. The host-controlled status bits may move only on the edge UPDATE_DLY cycles after a command. Both sticky fault pins must set and clear on the cycle after their causes. The two read windows must never overlap, and the bus must carry the live status word while the status window is open. The bench scenarios are what show the rest. They cover which commands qualify for dynamic bus control, the broadcast bit, and the capture of the illegal mark on the in_cmd edge. They also cover the exact window lengths and the rule that requests made during an open window are ignored.

// File: rtl/rtsr_pkg.sv
package rtsr_pkg;

    localparam int WORD_W = 16;
    localparam int RTA_W  = 5;
    localparam int SA_W   = 5;
    localparam int WC_W   = 5;

    localparam logic [RTA_W-1:0] BCAST_RTA = '1;
    localparam logic [WC_W-1:0]  DBC_CODE  = '0;

    typedef struct packed {
        logic [RTA_W-1:0] rta;
        logic             tr;
        logic [SA_W-1:0]  sa;
        logic [WC_W-1:0]  wc;
    } cmd_t;

    typedef struct packed {
        logic me;
        logic srq;
        logic bcr;
        logic busy;
        logic ssf;
        logic dbca;
        logic tf;
    } stat_bits_t;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_STAT = 2'd1,
        RD_BIT  = 2'd2
    } rd_mode_t;

    function automatic logic is_mode_cmd(cmd_t c);
        return (c.sa == '0) || (c.sa == '1);
    endfunction

    function automatic logic is_dbc_cmd(cmd_t c);
        return c.tr && is_mode_cmd(c) && (c.wc == DBC_CODE);
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(logic [RTA_W-1:0] rta, stat_bits_t s);
        return {rta, s.me, 1'b0, s.srq, 3'b000, s.bcr, s.busy, s.ssf, s.dbca, s.tf};
    endfunction

endpackage

// File: rtl/rtsr_update_timer.sv
module rtsr_update_timer #(
    parameter int DLY = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic fire
);
    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(DLY);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign fire = (cnt == CW'(1));
endmodule

// File: rtl/rtsr_flag.sv
module rtsr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/rtsr_read_port.sv
module rtsr_read_port
    import rtsr_pkg::*;
#(
    parameter int STAT_LEN = 6,
    parameter int BIT_LEN  = 8,
    parameter int BIT_W    = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_rd,
    input  logic              bit_rd,
    input  logic [WORD_W-1:0] status_word,
    input  logic [BIT_W-1:0]  bit_word,
    output logic              stat_en_n,
    output logic              bit_en_n,
    output logic [WORD_W-1:0] par_data
);
    localparam int MAXLEN = (STAT_LEN > BIT_LEN) ? STAT_LEN : BIT_LEN;
    localparam int CW     = $clog2(MAXLEN + 1);

    rd_mode_t         mode;
    logic [CW-1:0]    cnt;
    logic [BIT_W-1:0] bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= RD_IDLE;
            cnt   <= '0;
            bit_q <= '0;
        end else if (mode == RD_IDLE) begin
            if (stat_rd) begin
                mode <= RD_STAT;
                cnt  <= CW'(STAT_LEN - 1);
            end else if (bit_rd) begin
                mode  <= RD_BIT;
                cnt   <= CW'(BIT_LEN - 1);
                bit_q <= bit_word;
            end
        end else if (cnt == '0) begin
            mode <= RD_IDLE;
        end else begin
            cnt <= cnt - CW'(1);
        end
    end

    always_comb begin
        stat_en_n = (mode != RD_STAT);
        bit_en_n  = (mode != RD_BIT);
        unique case (mode)
            RD_STAT: par_data = status_word;
            RD_BIT:  par_data = WORD_W'(bit_q);
            default: par_data = '0;
        endcase
    end
endmodule

// File: rtl/rtsr_top.sv
module rtsr_top
    import rtsr_pkg::*;
#(
    parameter int UPDATE_DLY = 18,
    parameter int STAT_LEN   = 6,
    parameter int BIT_LEN    = 8,
    parameter int BIT_W      = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RTA_W-1:0]  rt_addr,
    input  logic              bcast_en,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              in_cmd,
    input  logic              illegal_n,
    input  logic              accept_dbc_n,
    input  logic              srq_n,
    input  logic              busy_n,
    input  logic              ssflag_n,
    input  logic              rtflag_n,
    input  logic              word_err,
    input  logic              selftest_fail,
    input  logic              wdog_to,
    input  logic              stat_tx_start,
    input  logic              stat_rd,
    input  logic              bit_rd,
    input  logic [BIT_W-1:0]  bit_word,
    output logic [WORD_W-1:0] status_word,
    output logic              mess_err_n,
    output logic              rt_fail_n,
    output logic              stat_en_n,
    output logic              bit_en_n,
    output logic [WORD_W-1:0] par_data
);
    cmd_t       cmd_in;
    stat_bits_t st;
    logic       dbc_q;
    logic       ill_q;
    logic       incmd_q;
    logic       incmd_rise;
    logic       upd_fire;
    logic       me_flag;
    logic       fail_flag;

    assign cmd_in     = cmd_t'(cmd_word);
    assign incmd_rise = in_cmd && !incmd_q;

    rtsr_update_timer #(.DLY(UPDATE_DLY)) i_timer (
        .clk   (clk),
        .rst   (rst),
        .start (cmd_valid),
        .fire  (upd_fire)
    );

    // Message-related state: command capture, illegal strobe, error bit
    always_ff @(posedge clk) begin
        if (rst) begin
            incmd_q <= 1'b0;
            ill_q   <= 1'b0;
            dbc_q   <= 1'b0;
            st.me   <= 1'b0;
            st.bcr  <= 1'b0;
        end else begin
            incmd_q <= in_cmd;
            if (cmd_valid) begin
                ill_q  <= 1'b0;
                dbc_q  <= is_dbc_cmd(cmd_in);
                st.bcr <= (cmd_in.rta == BCAST_RTA) && bcast_en;
                st.me  <= word_err;
            end else begin
                if (incmd_rise && !illegal_n) begin
                    ill_q <= 1'b1;
                    st.me <= 1'b1;
                end
                if (word_err) st.me <= 1'b1;
            end
        end
    end

    // Host-controlled bits, loaded only at the update instant
    always_ff @(posedge clk) begin
        if (rst) begin
            st.srq  <= 1'b0;
            st.busy <= 1'b0;
            st.ssf  <= 1'b0;
            st.tf   <= 1'b0;
            st.dbca <= 1'b0;
        end else if (upd_fire) begin
            st.srq  <= !srq_n;
            st.busy <= !busy_n;
            st.ssf  <= !ssflag_n;
            st.tf   <= !rtflag_n;
            st.dbca <= !accept_dbc_n && dbc_q && !ill_q && !st.bcr;
        end
    end

    assign status_word = pack_status(rt_addr, st);

    rtsr_flag i_me_flag (
        .clk (clk),
        .rst (rst),
        .set (word_err),
        .clr (cmd_valid),
        .q   (me_flag)
    );

    rtsr_flag i_fail_flag (
        .clk (clk),
        .rst (rst),
        .set (selftest_fail || wdog_to),
        .clr (stat_tx_start),
        .q   (fail_flag)
    );

    assign mess_err_n = !me_flag;
    assign rt_fail_n  = !fail_flag;

    rtsr_read_port #(
        .STAT_LEN (STAT_LEN),
        .BIT_LEN  (BIT_LEN),
        .BIT_W    (BIT_W)
    ) i_rd (
        .clk         (clk),
        .rst         (rst),
        .stat_rd     (stat_rd),
        .bit_rd      (bit_rd),
        .status_word (status_word),
        .bit_word    (bit_word),
        .stat_en_n   (stat_en_n),
        .bit_en_n    (bit_en_n),
        .par_data    (par_data)
    );
endmodule

// File: rtl/rtsr_checker.sv
module rtsr_checker #(
    parameter int UPDATE_DLY = 18
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        word_err,
    input logic        selftest_fail,
    input logic        wdog_to,
    input logic        stat_tx_start,
    input logic [15:0] status_word,
    input logic        mess_err_n,
    input logic        rt_fail_n,
    input logic        stat_en_n,
    input logic        bit_en_n,
    input logic [15:0] par_data
);
    localparam int CW = $clog2(UPDATE_DLY + 2) + 1;

    logic [CW-1:0] since;
    logic [4:0]    host_bits;

    assign host_bits = {status_word[8], status_word[3:0]};

    always_ff @(posedge clk) begin
        if (rst)                                 since <= '0;
        else if (cmd_valid)                      since <= CW'(1);
        else if (since == CW'(UPDATE_DLY + 1))   since <= '0;
        else if (since != '0)                    since <= since + CW'(1);
    end

    assert_host_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (since != CW'(UPDATE_DLY + 1)) |-> $stable(host_bits));

    assert_me_set_R7: assert property (@(posedge clk) disable iff (rst)
        word_err |=> !mess_err_n);

    assert_me_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !word_err) |=> mess_err_n);

    assert_fail_set_R8: assert property (@(posedge clk) disable iff (rst)
        (selftest_fail || wdog_to) |=> !rt_fail_n);

    assert_fail_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_tx_start && !selftest_fail && !wdog_to) |=> rt_fail_n);

    assert_windows_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(!stat_en_n && !bit_en_n));

    assert_status_on_bus_R9: assert property (@(posedge clk) disable iff (rst)
        !stat_en_n |-> (par_data == status_word));
endmodule

bind rtsr_top rtsr_checker #(.UPDATE_DLY(UPDATE_DLY)) i_rtsr_checker (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .word_err      (word_err),
    .selftest_fail (selftest_fail),
    .wdog_to       (wdog_to),
    .stat_tx_start (stat_tx_start),
    .status_word   (status_word),
    .mess_err_n    (mess_err_n),
    .rt_fail_n     (rt_fail_n),
    .stat_en_n     (stat_en_n),
    .bit_en_n      (bit_en_n),
    .par_data      (par_data)
);

// File: tb/test_rtsr_top.sv
module test_rtsr_top;
    localparam int UPD = 18;
    localparam int SL  = 6;
    localparam int BL  = 8;
    localparam int BW  = 14;
    localparam logic [4:0] MY_RTA = 5'd10;

    // vector: {cmd_word, bcast_en, pins{ill,dbc,srq,busy,ssf,tf}, expected status[10:0]}
    localparam int NV = 11;
    localparam logic [33:0] VEC [NV] = '{
        {16'h5062, 1'b0, 6'b110111, 11'h100},  // R3 service request
        {16'h5062, 1'b0, 6'b111001, 11'h00C},  // R3 busy + subsystem flag
        {16'h5400, 1'b0, 6'b101110, 11'h003},  // R4 dbc granted, R3 terminal flag
        {16'h5400, 1'b0, 6'b001111, 11'h400},  // R5 illegal blocks dbc, sets ME
        {16'h57E0, 1'b0, 6'b101111, 11'h002},  // R4 subaddress all ones
        {16'h5402, 1'b0, 6'b101111, 11'h000},  // R4 other mode code
        {16'h5000, 1'b0, 6'b101111, 11'h000},  // R4 T/R = 0
        {16'hF821, 1'b1, 6'b111111, 11'h010},  // R6 broadcast
        {16'hF821, 1'b0, 6'b111111, 11'h000},  // R6 broadcast disabled
        {16'hFC00, 1'b1, 6'b101111, 11'h010},  // R4 R6 broadcast dbc refused
        {16'h5062, 1'b0, 6'b100000, 11'h10D}   // R2 R3 all host bits
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0] rt_addr = MY_RTA;
    logic bcast_en = 1'b0, cmd_valid = 1'b0, in_cmd = 1'b0;
    logic [15:0] cmd_word = '0;
    logic illegal_n = 1'b1, accept_dbc_n = 1'b1, srq_n = 1'b1, busy_n = 1'b1;
    logic ssflag_n = 1'b1, rtflag_n = 1'b1;
    logic word_err = 1'b0, selftest_fail = 1'b0, wdog_to = 1'b0, stat_tx_start = 1'b0;
    logic stat_rd = 1'b0, bit_rd = 1'b0;
    logic [BW-1:0] bit_word = '0;
    logic [15:0] status_word, par_data;
    logic mess_err_n, rt_fail_n, stat_en_n, bit_en_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rtsr_top #(.UPDATE_DLY(UPD), .STAT_LEN(SL), .BIT_LEN(BL), .BIT_W(BW)) i_rtsr_top (
        .clk(clk), .rst(rst), .rt_addr(rt_addr), .bcast_en(bcast_en),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .in_cmd(in_cmd),
        .illegal_n(illegal_n), .accept_dbc_n(accept_dbc_n), .srq_n(srq_n),
        .busy_n(busy_n), .ssflag_n(ssflag_n), .rtflag_n(rtflag_n),
        .word_err(word_err), .selftest_fail(selftest_fail), .wdog_to(wdog_to),
        .stat_tx_start(stat_tx_start), .stat_rd(stat_rd), .bit_rd(bit_rd),
        .bit_word(bit_word), .status_word(status_word), .mess_err_n(mess_err_n),
        .rt_fail_n(rt_fail_n), .stat_en_n(stat_en_n), .bit_en_n(bit_en_n),
        .par_data(par_data)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_pins(input logic [5:0] p);
        {illegal_n, accept_dbc_n, srq_n, busy_n, ssflag_n, rtflag_n} = p;
    endtask

    task automatic run_cmd(input logic [15:0] w, input logic be, input logic [5:0] p);
        @(negedge clk);
        set_pins(p);
        bcast_en  = be;
        cmd_word  = w;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        in_cmd    = 1'b1;
        repeat (UPD + 2) @(negedge clk);
        in_cmd = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int lows_s, lows_b;
        repeat (3) @(negedge clk);
        check("R1 reset status", status_word, {MY_RTA, 11'h000});
        check("R1 reset pins", {12'h0, mess_err_n, rt_fail_n, stat_en_n, bit_en_n}, 16'h000F);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", status_word, {MY_RTA, 11'h000});
        check("R1 after reset pins", {12'h0, mess_err_n, rt_fail_n, stat_en_n, bit_en_n}, 16'h000F);

        for (int i = 0; i < NV; i++) begin
            run_cmd(VEC[i][33:18], VEC[i][17], VEC[i][16:11]);
            check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), status_word, {MY_RTA, VEC[i][10:0]});
        end

        // R3: host pins change with no command: bits hold
        @(negedge clk);
        set_pins(6'b111111);
        repeat (UPD + 10) @(negedge clk);
        check("R3 hold without update", status_word, {MY_RTA, 11'h10D});

        // R3: change pins right after update instant has passed in a new command
        run_cmd(16'h5062, 1'b0, 6'b111111);
        check("R3 cleared on update", status_word, {MY_RTA, 11'h000});

        // R5 / R7: word error
        pulse(word_err);
        @(negedge clk);
        check("R7 mess_err low", {15'h0, mess_err_n}, 16'h0000);
        check("R5 ME bit on word error", status_word, {MY_RTA, 11'h400});
        run_cmd(16'h5062, 1'b0, 6'b111111);
        check("R7 mess_err cleared", {15'h0, mess_err_n}, 16'h0001);
        check("R5 ME bit cleared", status_word, {MY_RTA, 11'h000});

        // R8: terminal fail
        pulse(selftest_fail);
        check("R8 fail on self-test", {15'h0, rt_fail_n}, 16'h0000);
        pulse(stat_tx_start);
        check("R8 cleared by tx start", {15'h0, rt_fail_n}, 16'h0001);
        pulse(wdog_to);
        check("R8 fail on watchdog", {15'h0, rt_fail_n}, 16'h0000);
        @(negedge clk);
        wdog_to = 1'b1; stat_tx_start = 1'b1;
        @(negedge clk);
        wdog_to = 1'b0; stat_tx_start = 1'b0;
        check("R8 fault persists over tx start", {15'h0, rt_fail_n}, 16'h0000);
        pulse(stat_tx_start);
        check("R8 cleared again", {15'h0, rt_fail_n}, 16'h0001);

        // R9: status window
        run_cmd(16'h5062, 1'b0, 6'b110111);
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R9 status on bus", par_data, {MY_RTA, 11'h100});
        lows_s = 0;
        for (int k = 0; k < SL + 3; k++) begin
            if (!stat_en_n) lows_s++;
            @(negedge clk);
        end
        check("R9 status window length", 16'(lows_s), 16'(SL));
        check("R10 bus idle", par_data, 16'h0000);

        // R10: BIT window, status request during it ignored
        @(negedge clk);
        bit_word = 14'h2ABC;
        bit_rd   = 1'b1;
        @(negedge clk);
        bit_rd   = 1'b0;
        bit_word = 14'h0000;
        stat_rd  = 1'b1;
        check("R10 BIT word on bus", par_data, 16'h2ABC);
        @(negedge clk);
        stat_rd = 1'b0;
        lows_b = 1; lows_s = 0;
        for (int k = 0; k < BL + 3; k++) begin
            if (!bit_en_n) lows_b++;
            if (!stat_en_n) lows_s++;
            @(negedge clk);
        end
        check("R10 BIT window length", 16'(lows_b), 16'(BL));
        check("R10 request during window ignored", 16'(lows_s), 16'h0000);

        // R10: simultaneous requests, status wins
        @(negedge clk);
        stat_rd = 1'b1; bit_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0; bit_rd = 1'b0;
        check("R10 status wins", {14'h0, stat_en_n, bit_en_n}, 16'h0001);
        repeat (SL + 2) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule